// File: doc/BRIEF.md
# Dual-Mode Bit-Rate Strobe Generator

This block turns the system clock into a one-cycle bit strobe that paces a serial bus engine. Two rate sources are available, chosen by a mode input. In fixed mode an integer counter divides the clock by a constant factor (27) times a programmable ratio. In offset mode a fractional phase accumulator sets the rate from a 9-bit offset, and the integer ratio is not used.

The offset rate is the clock divided by 33, multiplied by (1 + offset/512). With a 4 MHz clock, an offset of 0 gives about 121.2 kHz and an offset of 159 gives about 158.9 kHz. Dropping the enable or switching the mode restarts the rate source. The first strobe then comes one full period later. Both the ratio and the offset come from plain register inputs.

Top module: `bitrate_gen`

## Requirements
- R1: While rst_ni is low, stb_o is low. After release it stays low until the block is enabled.
- R2: In fixed mode (mode_i = 0) with ratio n ≥ 1, stb_o pulses once every 27·n clock cycles. The first pulse follows the 27·n-th enabled rising edge.
- R3: In fixed mode, a ratio of 0 behaves exactly like a ratio of 1 (period 27 cycles).
- R4: In offset mode (mode_i = 1), every enabled edge adds 512 + ofs_i to a phase sum. A pulse follows each edge where the sum reaches 16896, and 16896 is then removed from the sum. After k enabled edges from a restart, exactly floor(k·(512+ofs_i)/16896) pulses have occurred.
- R5: In offset mode, an offset of 0 gives a pulse exactly every 33 cycles.
- R6: In offset mode, div_i has no effect on stb_o.
- R7: While en_i is low, stb_o stays low and both rate sources are cleared. After re-enable, the first pulse comes one full period later.
- R8: A change of mode_i clears both rate sources on that edge, and no pulse follows that edge. The first pulse in the new mode comes one full period after the change edge.
- R9: stb_o is never high for two consecutive cycles.
- R10: In fixed mode, ofs_i has no effect on stb_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears the rate sources |
| mode_i | input | 1 | 0 = fixed integer divider, 1 = fractional offset |
| div_i | input | DIV_W | Fixed-mode ratio n (0 treated as 1) |
| ofs_i | input | OFS_W | Offset-mode rate offset |
| stb_o | output | 1 | One-cycle bit strobe |

## Verification
The bench builds the block with its default parameters: an 8-bit ratio, a 9-bit offset, a fixed factor of 27 and a fractional denominator of 33. With these values, ratios 0 to 3 and offsets 0 to 511 can be measured over windows of a few thousand cycles. This covers the full offset range, including the fastest case where the pulse spacing alternates between 16 and 17 cycles. The bench checks exact pulse counts and first-pulse positions against the closed-form rate rules. It also runs directed restarts through enable and through a mode change.

// File: rtl/bitrate_pkg.sv
package bitrate_pkg;
  typedef enum logic {
    MODE_FIXED  = 1'b0,
    MODE_OFFSET = 1'b1
  } rate_mode_e;
endpackage

// File: rtl/bitrate_restart.sv
module bitrate_restart (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mode_i,
  output logic clr_o
);
  logic mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode_i;
  end

  assign clr_o = !en_i || (mode_i != mode_q);
endmodule

// File: rtl/bitrate_fixdiv.sv
module bitrate_fixdiv #(
  parameter int DIV_W   = 8,
  parameter int FIX_MUL = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             hit_o
);
  localparam int CNT_W = $clog2(FIX_MUL << DIV_W);

  logic [CNT_W-1:0] cnt_q, lim;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  assign lim     = CNT_W'(FIX_MUL * int'(div_eff)) - CNT_W'(1);
  // >= keeps a shrinking ratio from running the counter past its limit
  assign hit_o   = run_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= hit_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/bitrate_fracacc.sv
module bitrate_fracacc #(
  parameter int OFS_W    = 9,
  parameter int FRAC_DEN = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             hit_o
);
  localparam int ONE     = 1 << OFS_W;
  localparam int ACC_LIM = FRAC_DEN * ONE;
  localparam int ACC_W   = $clog2(ACC_LIM + 2 * ONE);

  logic [ACC_W-1:0] acc_q, sum;

  assign sum   = acc_q + ACC_W'(ONE) + ACC_W'(ofs_i);
  assign hit_o = run_i && (sum >= ACC_W'(ACC_LIM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (run_i) acc_q <= hit_o ? sum - ACC_W'(ACC_LIM) : sum;
  end
endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen
  import bitrate_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int OFS_W    = 9,
  parameter int FIX_MUL  = 27,
  parameter int FRAC_DEN = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             stb_o
);
  rate_mode_e mode;
  logic clr, fix_hit, ofs_hit, fix_run, ofs_run, stb_q;

  assign mode    = rate_mode_e'(mode_i);
  assign fix_run = !clr && (mode == MODE_FIXED);
  assign ofs_run = !clr && (mode == MODE_OFFSET);

  bitrate_restart i_restart (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .mode_i(mode_i),
    .clr_o (clr)
  );

  bitrate_fixdiv #(.DIV_W(DIV_W), .FIX_MUL(FIX_MUL)) i_fixdiv (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .run_i (fix_run),
    .div_i (div_i),
    .hit_o (fix_hit)
  );

  bitrate_fracacc #(.OFS_W(OFS_W), .FRAC_DEN(FRAC_DEN)) i_fracacc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .run_i (ofs_run),
    .ofs_i (ofs_i),
    .hit_o (ofs_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= fix_hit || ofs_hit;
  end

  assign stb_o = stb_q;
endmodule

// File: rtl/bitrate_chk.sv
module bitrate_chk #(
  parameter int OFS_W    = 9,
  parameter int FIX_MUL  = 27,
  parameter int FRAC_DEN = 33
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic mode_i,
  input logic stb_o
);
  localparam int ONE     = 1 << OFS_W;
  localparam int MIN_GAP = (FRAC_DEN * ONE) / (2 * ONE - 1);

  logic        mode_prev;
  logic [15:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_prev <= 1'b0;
      gap_q     <= '0;
    end else begin
      mode_prev <= mode_i;
      if (!en_i || mode_i != mode_prev) gap_q <= '0;
      else if (stb_o)                   gap_q <= 16'd1;
      else if (gap_q != 16'hffff)       gap_q <= gap_q + 16'd1;
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !stb_o);
  assert_fixed_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o && !mode_prev) |-> (gap_q >= 16'(FIX_MUL)));
  assert_offset_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o && mode_prev) |-> (gap_q >= 16'(MIN_GAP)));
  assert_quiet_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !stb_o);
  assert_mode_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (mode_i != mode_prev)) |=> !stb_o);
  assert_single_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
endmodule

bind bitrate_gen bitrate_chk #(
  .OFS_W(OFS_W), .FIX_MUL(FIX_MUL), .FRAC_DEN(FRAC_DEN)
) i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .mode_i(mode_i),
  .stb_o (stb_o)
);

// File: tb/test_bitrate_gen.sv
`timescale 1ns/1ps
module test_bitrate_gen;
  localparam int DIV_W = 8;
  localparam int OFS_W = 9;
  localparam int LIM   = 33 * 512;

  typedef struct packed {
    logic        mode;
    logic [7:0]  div;
    logic [8:0]  ofs;
    logic [15:0] win;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd1,   9'd0,   16'd300},   // R2 n=1
    '{1'b0, 8'd3,   9'd0,   16'd500},   // R2 n=3
    '{1'b0, 8'd0,   9'd0,   16'd300},   // R3 n=0
    '{1'b0, 8'd2,   9'd511, 16'd400},   // R10 ofs ignored
    '{1'b1, 8'd0,   9'd0,   16'd2000},  // R5 offset 0
    '{1'b1, 8'd200, 9'd63,  16'd2000},  // R4 R6 div ignored
    '{1'b1, 8'd7,   9'd122, 16'd2000},  // R4
    '{1'b1, 8'd1,   9'd159, 16'd2000},  // R4
    '{1'b1, 8'd0,   9'd511, 16'd2000}   // R4 fastest
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0;
  logic mode = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic [OFS_W-1:0] ofs = '0;
  logic stb;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  bitrate_gen i_bitrate_gen (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .en_i  (en),
    .mode_i(mode),
    .div_i (div),
    .ofs_i (ofs),
    .stb_o (stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_win(input int w, output int n, output int first, output int dbl);
    bit prev = 1'b0;
    n = 0; first = 0; dbl = 0;
    for (int k = 1; k <= w; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (stb) begin
        n++;
        if (first == 0) first = k;
        if (prev) dbl++;
      end
      prev = stb;
    end
  endtask

  function automatic int exp_count(vec_t v);
    int p;
    if (v.mode) return (int'(v.win) * (512 + int'(v.ofs))) / LIM;
    p = 27 * ((v.div == 0) ? 1 : int'(v.div));
    return int'(v.win) / p;
  endfunction

  function automatic int exp_first(vec_t v);
    int step;
    if (v.mode) begin
      step = 512 + int'(v.ofs);
      return (LIM + step - 1) / step;
    end
    return 27 * ((v.div == 0) ? 1 : int'(v.div));
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int n, first, dbl;
    // R1: reset holds strobe low even with enable set
    en = 1'b1; div = 8'd1;
    repeat (40) begin
      @(negedge clk);
      if (stb) n++;
    end
    n = 0;
    check(stb == 1'b0, "R1 during reset", int'(stb), 0);
    @(negedge clk); en = 1'b0; rst_ni = 1'b1;
    run_win(40, n, first, dbl);
    check(n == 0, "R1 idle after reset", n, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      en = 1'b0; mode = VECS[i].mode; div = VECS[i].div; ofs = VECS[i].ofs;
      repeat (2) @(posedge clk);
      @(negedge clk); en = 1'b1;
      run_win(int'(VECS[i].win), n, first, dbl);
      check(n == exp_count(VECS[i]), VECS[i].mode ? "R4/R5/R6 count" : "R2/R3/R10 count",
            n, exp_count(VECS[i]));
      check(first == exp_first(VECS[i]), VECS[i].mode ? "R4/R5 first" : "R2/R3 first",
            first, exp_first(VECS[i]));
      check(dbl == 0, "R9 single cycle", dbl, 0);
    end

    // R7: enable low mid-run clears and silences
    @(negedge clk);
    en = 1'b0; mode = 1'b0; div = 8'd1; ofs = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); en = 1'b1;
    run_win(10, n, first, dbl);
    @(negedge clk); en = 1'b0;
    run_win(40, n, first, dbl);
    check(n == 0, "R7 silent while disabled", n, 0);
    @(negedge clk); en = 1'b1;
    run_win(60, n, first, dbl);
    check(first == 27, "R7 restart first", first, 27);
    check(n == 2, "R7 restart count", n, 2);

    // R8: mode change while enabled restarts in new mode
    @(negedge clk);
    en = 1'b0; mode = 1'b0; div = 8'd1;
    repeat (2) @(posedge clk);
    @(negedge clk); en = 1'b1;
    run_win(20, n, first, dbl);
    @(negedge clk); mode = 1'b1; ofs = '0;
    run_win(80, n, first, dbl);
    check(first == 34, "R8 first after change", first, 34);
    check(n == 2, "R8 count after change", n, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule